// File: doc/BRIEF.md
# Parallel Bit-Reversal Reorderer for Short Frames

This block sits after a parallel pipelined FFT or a similar stream source. Each frame holds N = 2^n words and arrives P = 2^p words per clock with no idle cycles. The block reorders each frame into bit-reversed index order and keeps the same throughput. This version supports only frames that satisfy N ≤ P², so there are at most as many time bits (s = n − p) as lane bits.

Index bit j trades places with index bit n−1−j. Some lane bits have a partner that is also a lane bit. Those lanes are reordered by fixed wiring, which needs no registers and no multiplexers. Each remaining time bit is exchanged with its partner lane bit in a serial-parallel stage. A stage has two delay lines per lane pair and a 2:1 multiplexer on each lane. Taken together, the stages hold N − P words, use P·log2(N/P) multiplexers and add N/P − 1 cycles of latency.

A one-cycle start strobe marks the first beat of a frame. After that the stream runs continuously, and frame timing is kept by a counter that wraps every N/P cycles.

Top module: `bitrev_par`

## Requirements
- R1: After reset, out_valid stays low until the first in_start has been seen and the warm-up has passed.
- R2: out_valid goes high exactly N/P − 1 cycles after the first in_start and then stays high.
- R3: The input word at frame cycle t on lane l has index t·P + l. Lane l occupies bits [l·W +: W] on both buses. Output frame cycle k, lane l, carries the input word whose index is the n-bit reversal of k·P + l.
- R4: Frames that follow each other with no gap are each reordered correctly. The frame counter wraps from N/P − 1 to 0 with no strobe.
- R5: When p − s ≥ 2, lane bits whose partner is also a lane bit are exchanged by wiring alone. The result still matches the ordering of R3 (for example N = 64 with P = 16).
- R6: With N = 16 and P = 8, the first reordered frame appears one cycle after in_start.
- R7: A later in_start that falls off the frame grid moves the frame boundary to that cycle. Frames from then on are reordered relative to the new start from N/P − 1 cycles later, and out_valid stays high. A strobe that falls on the frame grid changes nothing.
- R8: Word contents pass unchanged, including words that are all zeros and all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_start | input | 1 | High on the first beat of a frame |
| in_data | input | P·W | P input words, lane l at bits [l·W +: W] |
| out_valid | output | 1 | High when out_data carries reordered frame data |
| out_data | output | P·W | P reordered words, same lane packing |

## Verification
A frame-start strobe can land in the same cycle as beats of the previous frame that are still inside the exchange stages. The strobe resets the frame counter, which drives every stage's swap selects, while older words are still moving through the delay lines. The bench provokes this with a strobe that falls off the frame grid in the middle of a stream. It judges the result by two things: out_valid must stay high, and every frame after the new start must match the bit-reversal reference. The bench also places a strobe on the frame grid in the smaller configuration, and there the output must show no disturbance at all.

// File: rtl/brv_pkg.sv
package brv_pkg;

  // Lane permutation for pairs where both partners are lane bits:
  // bit b (sb <= b < pb) takes the value of bit pb+sb-1-b.
  function automatic int lane_map(int l, int pb, int sb);
    int r;
    r = l;
    for (int b = sb; b < pb; b++) begin
      r = (r & ~(1 << b)) | (((l >> (pb + sb - 1 - b)) & 1) << b);
    end
    return r;
  endfunction

  // Total delay accumulated ahead of exchange stage a.
  function automatic int stage_ofs(int a);
    return (1 << a) - 1;
  endfunction

endpackage

// File: rtl/brv_delay.sv
module brv_delay #(
  parameter int W   = 16,
  parameter int DLY = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] sr [DLY];

  always_ff @(posedge clk) begin
    sr[0] <= din;
    for (int i = 1; i < DLY; i++) sr[i] <= sr[i-1];
  end

  assign dout = sr[DLY-1];

  if (DLY <= 4) begin : g_chk
    // R3
    delay_chk: assert property (@(posedge clk) disable iff (rst)
      dout == $past(din, DLY));
  end
endmodule

// File: rtl/brv_sp_stage.sv
module brv_sp_stage #(
  parameter int W    = 16,
  parameter int P    = 16,
  parameter int LBIT = 0,
  parameter int DLY  = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           swap,
  input  logic [P*W-1:0] din,
  output logic [P*W-1:0] dout
);
  for (genvar l = 0; l < P; l++) begin : g_lane
    if (((l >> LBIT) & 1) == 0) begin : g_pair
      localparam int V = l + (1 << LBIT);
      logic [W-1:0] v_dly, mux_a, mux_b;

      brv_delay #(.W(W), .DLY(DLY)) u_pre (
        .clk(clk), .rst(rst), .din(din[V*W +: W]), .dout(v_dly));

      assign mux_a = swap ? v_dly : din[l*W +: W];
      assign mux_b = swap ? din[l*W +: W] : v_dly;

      brv_delay #(.W(W), .DLY(DLY)) u_post (
        .clk(clk), .rst(rst), .din(mux_a), .dout(dout[l*W +: W]));

      assign dout[V*W +: W] = mux_b;
    end
  end
endmodule

// File: rtl/brv_lane_wire.sv
module brv_lane_wire #(
  parameter int W  = 16,
  parameter int P  = 16,
  parameter int PB = 4,
  parameter int SB = 2
) (
  input  logic [P*W-1:0] din,
  output logic [P*W-1:0] dout
);
  for (genvar l = 0; l < P; l++) begin : g_map
    localparam int M = brv_pkg::lane_map(l, PB, SB);
    assign dout[M*W +: W] = din[l*W +: W];
  end
endmodule

// File: rtl/brv_ctrl.sv
module brv_ctrl #(
  parameter int SB  = 2,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic [SB-1:0] tcur,
  output logic          out_valid
);
  localparam int VW = $clog2(LAT + 1);

  logic [SB-1:0] cnt_q;
  logic          seen_q;
  logic [VW-1:0] vcnt_q;

  assign tcur = start ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      vcnt_q <= '0;
    end else begin
      cnt_q <= tcur + SB'(1);
      if (start && !seen_q) begin
        seen_q <= 1'b1;
        vcnt_q <= VW'(1);
      end else if (seen_q && vcnt_q != VW'(LAT)) begin
        vcnt_q <= vcnt_q + VW'(1);
      end
    end
  end

  assign out_valid = seen_q && (vcnt_q == VW'(LAT));

  // checker: cycles since the first strobe, saturating at LAT
  logic     ck_seen;
  int       ck_cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      ck_seen <= 1'b0;
      ck_cnt  <= 0;
    end else if (start && !ck_seen) begin
      ck_seen <= 1'b1;
      ck_cnt  <= 1;
    end else if (ck_seen && ck_cnt < LAT) begin
      ck_cnt <= ck_cnt + 1;
    end
  end

  // R2
  warmup_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (ck_seen && ck_cnt == LAT));
  // R2
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> out_valid);
  // R7
  realign_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (cnt_q == SB'(1)));
  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!start && cnt_q == '1) |=> (cnt_q == '0));
endmodule

// File: rtl/bitrev_par.sv
module bitrev_par #(
  parameter int W = 16,
  parameter int N = 64,
  parameter int P = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_start,
  input  logic [P*W-1:0] in_data,
  output logic           out_valid,
  output logic [P*W-1:0] out_data
);
  localparam int NB  = $clog2(N);
  localparam int PB  = $clog2(P);
  localparam int SB  = NB - PB;
  localparam int FR  = N / P;
  localparam int LAT = FR - 1;

  if (N > P * P || N < 2 * P || (1 << NB) != N || (1 << PB) != P) begin : g_bad
    $error("bitrev_par: need powers of two with 2P <= N <= P*P");
  end

  logic [SB-1:0]  tcur;
  logic [SB-1:0]  sel;
  logic [P*W-1:0] st [SB+1];

  brv_ctrl #(.SB(SB), .LAT(LAT)) u_ctrl (
    .clk(clk), .rst(rst), .start(in_start), .tcur(tcur), .out_valid(out_valid));

  brv_lane_wire #(.W(W), .P(P), .PB(PB), .SB(SB)) u_wire (
    .din(in_data), .dout(st[0]));

  for (genvar a = 0; a < SB; a++) begin : g_stage
    localparam logic [SB-1:0] OFS = SB'(brv_pkg::stage_ofs(a));
    logic [SB-1:0] lt;
    assign lt     = tcur - OFS;
    assign sel[a] = lt[a];

    brv_sp_stage #(.W(W), .P(P), .LBIT(SB - 1 - a), .DLY(1 << a)) u_sp (
      .clk(clk), .rst(rst), .swap(sel[a]), .din(st[a]), .dout(st[a+1]));
  end

  assign out_data = st[SB];
endmodule

// File: tb/sim_bitrev_par.sv
`timescale 1ns/1ps
module sim_bitrev_par;
  localparam int W = 16;
  localparam int N0 = 64, P0 = 16, FR0 = 4, LAT0 = 3, NB0 = 6;
  localparam int N1 = 16, P1 = 8,  FR1 = 2, LAT1 = 1, NB1 = 4;
  localparam int NC = 140;
  localparam int REAL = 70;

  logic clk = 1'b0, rst = 1'b1;
  logic s0 = 1'b0, s1 = 1'b0;
  logic [P0*W-1:0] d0 = '0;
  logic [P1*W-1:0] d1 = '0;
  logic v0, v1;
  logic [P0*W-1:0] q0;
  logic [P1*W-1:0] q1;

  logic [W-1:0] mem0 [0:4095];
  logic [W-1:0] mem1 [0:4095];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bitrev_par #(.W(W), .N(N0), .P(P0)) u0 (
    .clk(clk), .rst(rst), .in_start(s0), .in_data(d0), .out_valid(v0), .out_data(q0));
  bitrev_par #(.W(W), .N(N1), .P(P1)) u1 (
    .clk(clk), .rst(rst), .in_start(s1), .in_data(d1), .out_valid(v1), .out_data(q1));

  function automatic int rev(int x, int nb);
    int r = 0;
    for (int i = 0; i < nb; i++) r = r | (((x >> i) & 1) << (nb - 1 - i));
    return r;
  endfunction

  function automatic logic [W-1:0] pick(int fr, int idx);
    if (fr == 1) return '0;
    if (fr == 2) return '1;
    if (fr == 3) return W'(idx);
    return W'($urandom);
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, expv);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: idle after reset, no strobe
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      d0 = {P0{16'hbeef}};
      #1;
      chk(v0 == 1'b0, "R1 u0 valid", v0, 0);
      chk(v1 == 1'b0, "R1 u1 valid", v1, 0);
    end
    begin
      int base0 = 0, skip0 = LAT0;
      for (int c = 0; c < NC; c++) begin
        int rel0, rel1;
        @(negedge clk);
        if (c == REAL) begin base0 = REAL; skip0 = REAL + LAT0; end
        rel0 = c - base0;
        rel1 = c;
        s0 = (c == 0) || (c == REAL);
        s1 = (c == 0) || (c == 40);
        for (int l = 0; l < P0; l++) begin
          logic [W-1:0] w = pick(rel0 / FR0, rel0 * P0 + l);
          mem0[rel0 * P0 + l] = w;
          d0[l*W +: W] = w;
        end
        for (int l = 0; l < P1; l++) begin
          logic [W-1:0] w = pick(rel1 / FR1, rel1 * P1 + l);
          mem1[rel1 * P1 + l] = w;
          d1[l*W +: W] = w;
        end
        #1;
        // R2 / R7: valid rises after the warm-up and never drops
        chk(v0 == (c >= LAT0), "R2 u0 valid", v0, (c >= LAT0));
        // R6: short frame, one-cycle latency
        chk(v1 == (c >= LAT1), "R6 u1 valid", v1, (c >= LAT1));
        if (c >= skip0 && rel0 >= LAT0) begin
          int o = rel0 - LAT0;
          int f = o / FR0, k = o % FR0;
          for (int l = 0; l < P0; l++) begin
            logic [W-1:0] e = mem0[f * N0 + rev(k * P0 + l, NB0)];
            logic [W-1:0] g = q0[l*W +: W];
            if (base0 != 0)      chk(g == e, "R7 u0 data after realign", g, e);
            else if (f == 1 || f == 2) chk(g == e, "R8 u0 zero/one words", g, e);
            else if (f > 0)      chk(g == e, "R4 u0 back-to-back", g, e);
            else                 chk(g == e, "R3 R5 u0 order", g, e);
          end
        end
        if (rel1 >= LAT1) begin
          int o = rel1 - LAT1;
          int f = o / FR1, k = o % FR1;
          for (int l = 0; l < P1; l++) begin
            logic [W-1:0] e = mem1[f * N1 + rev(k * P1 + l, NB1)];
            logic [W-1:0] g = q1[l*W +: W];
            chk(g == e, "R6 R3 u1 order", g, e);
          end
        end
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule